// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable logic fabric. It takes a single sum-of-products bit and a small set of per-cell control terms. Depending on a static mode field it acts as a plain combinational pass-through, a D flip-flop, a T flip-flop or a latch. Whatever the mode, an inversion control sets the polarity of the visible result. The storage element is clocked or enabled by one of four sources: a global clock or a per-cell clock term, each available true or inverted. Independent reset and preset terms force the stored value. For test, a preload control writes the stored value from the pad data, and an observe control exposes the stored value through the normal output path.

The whole cell lives in one system clock domain. The selected clock source is sampled on every system clock. A rise of the selected, polarity-adjusted level is treated as the active edge, and the new stored value appears after the system clock edge that samples that rise. The cell drives the pad path, with its output enable passed through, and a separate feedback output. The feedback output always carries the same result as the pad path, whatever the output enable is doing.

Top module: `omc_cell`

## Requirements
- R1: With `mode` = 0 (combinational) and `observe` low, the result equals `sop` in the same cycle and the stored value is not changed by `sop`.
- R2: `pad_q` equals the result XOR `inv_out` in every mode, so each behaviour has an active-high variant and an active-low variant.
- R3: With `mode` = 1 (D register), an active edge loads `sop` into the stored value, and the result shows the stored value.
- R4: With `mode` = 2 (T register), an active edge with `sop` = 1 inverts the stored value, and an active edge with `sop` = 0 keeps it.
- R5: With `mode` = 3 (latch), the cell is transparent while the polarity-adjusted enable level is 0: the result follows `sop` in the same cycle and is captured every system clock. While that level is 1, the stored value holds.
- R6: `clk_sel` picks the clock or enable level: 0 selects `gclk_in`, 1 selects the inverse of `gclk_in`, 2 selects `clk_pt`, and 3 selects the inverse of `clk_pt`. An active edge is a 0-to-1 change of that level between two consecutive system clocks.
- R7: `areset` forces the stored value to 0 at the next system clock, and `apreset` alone forces it to 1. When both are high, the result is 0. In the three storage modes, the result shows the forced value during the same cycle.
- R8: `fb_q` always equals `pad_q`, whatever the value of `oe`. `pad_en` equals `oe`.
- R9: While `rst_n` is low, and after it is released, the stored value is 0. In the storage modes this makes `pad_q` equal `inv_out`. The sampled clock level resets to 1, so a source that is already high after reset gives no edge.
- R10: With `preload` high, and neither reset nor preset asserted, the stored value loads `pad_din` at the next system clock in any mode.
- R11: With `observe` high, the data term is taken as 0 and the result shows the stored value. Mode 2 keeps T behaviour; every other mode acts as a D register.
- R12: Changing `mode`, `inv_out` or `oe` never alters the stored value. Changing `clk_sel` alters it only through an edge of the newly selected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| mode | input | 2 | 0 combinational, 1 D register, 2 T register, 3 latch |
| inv_out | input | 1 | Invert the visible result |
| clk_sel | input | 2 | Clock or enable source select |
| gclk_in | input | 1 | Global clock level |
| clk_pt | input | 1 | Per-cell clock term |
| sop | input | 1 | Sum-of-products data bit |
| areset | input | 1 | Reset term |
| apreset | input | 1 | Preset term |
| oe | input | 1 | Output enable term |
| preload | input | 1 | Test preload control |
| pad_din | input | 1 | Pad data used by preload |
| observe | input | 1 | Test observe control |
| pad_q | output | 1 | Result toward the pad |
| pad_en | output | 1 | Output enable toward the pad |
| fb_q | output | 1 | Feedback result |

## Verification
The bench aims at four corner cases.

- **Reset and preset asserted together.** A design that let preset win would show 1 instead of 0.
- **A clock source that sits high when reset is released.** A design that resets the sampled level to 0 would register a spurious edge and take data.
- **Inverted clock selects and latch enable polarity.** A design that swapped the enable sense would hold while it should be transparent, which shows up as a stale result under random data.
- **Observe while in latch or combinational mode.** A design that kept the configured path would show live `sop` instead of the stored value.

// File: rtl/omc_cell.sv
module omc_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       inv_out,
  input  logic [1:0] clk_sel,
  input  logic       gclk_in,
  input  logic       clk_pt,
  input  logic       sop,
  input  logic       areset,
  input  logic       apreset,
  input  logic       oe,
  input  logic       preload,
  input  logic       pad_din,
  input  logic       observe,
  output logic       pad_q,
  output logic       pad_en,
  output logic       fb_q
);
  localparam logic [1:0] M_COMB = 2'd0;
  localparam logic [1:0] M_DREG = 2'd1;
  localparam logic [1:0] M_TREG = 2'd2;
  localparam logic [1:0] M_LAT  = 2'd3;

  logic       store_q;
  logic       lvl_d;
  logic       en_lvl;
  logic       edge_hit;
  logic       data;
  logic       result;
  logic [1:0] eff_mode;

  assign en_lvl   = (clk_sel[1] ? clk_pt : gclk_in) ^ clk_sel[0];
  assign edge_hit = en_lvl & ~lvl_d;
  assign data     = observe ? 1'b0 : sop;
  assign eff_mode = observe ? ((mode == M_TREG) ? M_TREG : M_DREG) : mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      lvl_d   <= 1'b1;
    end else begin
      lvl_d <= en_lvl;
      if (areset)       store_q <= 1'b0;
      else if (apreset) store_q <= 1'b1;
      else if (preload) store_q <= pad_din;
      else begin
        case (eff_mode)
          M_DREG:  if (edge_hit) store_q <= data;
          M_TREG:  if (edge_hit) store_q <= store_q ^ data;
          M_LAT:   if (!en_lvl)  store_q <= data;
          default: store_q <= store_q;
        endcase
      end
    end
  end

  always_comb begin
    if (eff_mode == M_COMB)                 result = data;
    else if (areset)                        result = 1'b0;
    else if (apreset)                       result = 1'b1;
    else if (eff_mode == M_LAT && !en_lvl)  result = data;
    else                                    result = store_q;
  end

  assign pad_q  = result ^ inv_out;
  assign fb_q   = pad_q;
  assign pad_en = oe;
endmodule

module omc_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       sop,
  input logic       areset,
  input logic       apreset,
  input logic       preload,
  input logic       pad_din,
  input logic       observe,
  input logic       en_lvl,
  input logic       store_q,
  input logic       pad_q,
  input logic       fb_q
);
  logic quiet;
  assign quiet = !areset && !apreset && !preload;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    areset |=> !store_q); // R7
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (apreset && !areset) |=> store_q); // R7
  AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !areset && !apreset) |=> store_q == $past(pad_din)); // R10
  AST_COMB_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !observe && mode == 2'd0) |=> $stable(store_q)); // R1
  AST_T_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && mode == 2'd2 && !sop) |=> $stable(store_q)); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !observe && mode == 2'd3 && en_lvl) |=> $stable(store_q)); // R5
  AST_FB_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    fb_q == pad_q); // R8
endmodule

bind omc_cell omc_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sop(sop), .areset(areset),
  .apreset(apreset), .preload(preload), .pad_din(pad_din), .observe(observe),
  .en_lvl(en_lvl), .store_q(store_q), .pad_q(pad_q), .fb_q(fb_q)
);

// File: tb/omc_cell_tb.sv
module omc_cell_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0, clk_sel = 0;
  logic inv_out = 0, gclk_in = 0, clk_pt = 0, sop = 0, areset = 0, apreset = 0;
  logic oe = 0, preload = 0, pad_din = 0, observe = 0;
  logic pad_q, pad_en, fb_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit mq;
  bit mprev;

  omc_cell u_dut (.clk(clk), .rst_n(rst_n), .mode(mode), .inv_out(inv_out),
    .clk_sel(clk_sel), .gclk_in(gclk_in), .clk_pt(clk_pt), .sop(sop),
    .areset(areset), .apreset(apreset), .oe(oe), .preload(preload),
    .pad_din(pad_din), .observe(observe), .pad_q(pad_q), .pad_en(pad_en), .fb_q(fb_q));

  always #(CLK_P/2) clk = ~clk;

  function automatic bit sel_level();
    case (clk_sel)
      2'd0: return gclk_in;
      2'd1: return !gclk_in;
      2'd2: return clk_pt;
      default: return !clk_pt;
    endcase
  endfunction

  // Reference behaviour, written from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = 0; mprev = 1;
    end else begin
      bit lv, rise, d;
      int kind;
      lv = sel_level();
      rise = lv && !mprev;
      mprev = lv;
      d = observe ? 1'b0 : sop;
      kind = observe ? ((mode == 2) ? 2 : 1) : int'(mode);
      if (areset) mq = 0;
      else if (apreset) mq = 1;
      else if (preload) mq = pad_din;
      else if (kind == 1 && rise) mq = d;
      else if (kind == 2 && rise && d) mq = !mq;
      else if (kind == 3 && !lv) mq = d;
    end
  end

  function automatic bit expect_out();
    bit r;
    int kind;
    kind = observe ? ((mode == 2) ? 2 : 1) : int'(mode);
    if (kind == 0) r = sop;
    else if (areset) r = 0;
    else if (apreset) r = 1;
    else if (kind == 3 && !sel_level()) r = sop;
    else r = mq;
    return r ^ inv_out;
  endfunction

  task automatic check(string tag);
    bit e;
    e = expect_out();
    n_chk++;
    if (pad_q !== e) begin n_fail++; $display("FAIL %s pad_q actual %b expected %b", tag, pad_q, e); end
    n_chk++;
    if (fb_q !== e) begin n_fail++; $display("FAIL R8 fb_q actual %b expected %b", fb_q, e); end
    n_chk++;
    if (pad_en !== oe) begin n_fail++; $display("FAIL R8 pad_en actual %b expected %b", pad_en, oe); end
  endtask

  task automatic phase(string tag, int n, int pg, int ppt, int par, int pap, int ppl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (($urandom % 100) < pg)  gclk_in = ~gclk_in;
      if (($urandom % 100) < ppt) clk_pt = ~clk_pt;
      sop = $urandom; oe = $urandom; pad_din = $urandom;
      areset  = ($urandom % 100) < par;
      apreset = ($urandom % 100) < pap;
      preload = ($urandom % 100) < ppl;
      #1 check(tag);
    end
    @(negedge clk);
    areset = 0; apreset = 0; preload = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mode = 1; gclk_in = 1;
    repeat (2) @(negedge clk);
    #1 check("R9"); inv_out = 1; #1 check("R9");
    @(negedge clk); rst_n = 1; inv_out = 0;
    #1 check("R9");
    @(negedge clk); #1 check("R9_no_edge_after_release");

    mode = 0;
    phase("R1", 20, 50, 50, 0, 0, 0);
    inv_out = 1;
    phase("R2", 20, 50, 50, 0, 0, 0);

    for (int p = 0; p < 2; p++) begin
      inv_out = p[0];
      mode = 1; clk_sel = 0; phase("R3", 60, 40, 0, 0, 0, 0);
      mode = 2;              phase("R4", 60, 40, 0, 0, 0, 0);
      mode = 3;              phase("R5", 60, 40, 0, 0, 0, 0);
    end

    for (int s = 0; s < 4; s++) begin
      clk_sel = s[1:0];
      mode = 1; phase("R6", 40, 40, 40, 0, 0, 0);
      mode = 3; phase("R6", 30, 40, 40, 0, 0, 0);
    end

    for (int m = 0; m < 4; m++) begin
      mode = m[1:0]; clk_sel = 2;
      phase("R7", 40, 40, 40, 20, 20, 0);
    end
    @(negedge clk); mode = 1; areset = 1; apreset = 1; #1 check("R7_both");
    @(negedge clk); areset = 0; #1 check("R7_both");
    @(negedge clk); apreset = 0; #1 check("R7_both");

    for (int m = 0; m < 4; m++) begin
      mode = m[1:0]; phase("R10", 30, 30, 30, 5, 5, 40);
    end

    observe = 1;
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0]; phase("R11", 30, 40, 40, 0, 10, 10);
    end
    observe = 0;

    @(negedge clk); apreset = 1; mode = 2; clk_sel = 0; #1 check("R12");
    @(negedge clk); apreset = 0; sop = 0; #1 check("R12");
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); mode = m[1:0]; inv_out = m[2]; oe = ~oe; sop = 0; #1 check("R12");
    end
    mode = 2; clk_sel = 1;
    phase("R12", 20, 40, 40, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule